// File: doc/BRIEF.md
# Split-Byte Double-Buffered Converter Code Loader

This block is the digital front end of a 12-bit converter that hangs off an 8-bit bus. A host writes the word in two parts: a low byte and a high nibble, each under its own active-low select, qualified by a shared active-low write strobe. The parts are collected in an input register. A separate active-low load strobe copies that word into a second register, the DAC register, whose contents are the code presented to the external converter. An active-low clear zeroes the DAC register only.

The control pins are asynchronous to the system clock. They pass through a synchronizer, and the data bus is delayed by the same number of stages so that data and strobes stay aligned. Level-sensitive latch behaviour is rebuilt synchronously. While a select and the write strobe are both low, the selected field follows the bus on every clock. While the load strobe is low, the DAC register follows the input register, and that includes a value being written in the same cycle. A one-cycle pulse marks every change of the output code.

Top module: `dac_byte_loader`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, the output code is zero and the change pulse is low.
- R2: While the low-byte select and the write strobe are both low, code bits 7:0 of the input register follow bus bits 7:0 on every clock. Once either input goes high, those bits hold their value.
- R3: While the high-nibble select and the write strobe are both low, input register bits 11:8 follow bus bits 3:0. Bus bits 7:4 have no effect. Once either input goes high, those bits hold.
- R4: While the load strobe is low and the clear is high, the output code follows the input register. While the load strobe is high, the output code holds.
- R5: With the high-nibble select, the write strobe and the load strobe all low together, the new nibble reaches the output code in the same clock in which it enters the input register.
- R6: With both selects high, toggling the write strobe and changing the bus leave the input register unchanged. This is observed through a later load.
- R7: A low clear forces the output code to zero and leaves the input register unchanged, so a later load restores the stored word.
- R8: The clear takes priority over the load strobe. While both are low, the output code stays zero.
- R9: A control pin change takes effect at the third rising clock edge after it is applied, given the default two synchronizer stages. The output does not change at the second edge.
- R10: The change pulse is high for exactly one cycle, in the cycle in which a new output code first appears. It stays low when a load rewrites the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | 8 | Data bus |
| lo_sel_n | input | 1 | Low-byte select, active low |
| hi_sel_n | input | 1 | High-nibble select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load strobe into DAC register, active low |
| clr_n | input | 1 | Clear of the DAC register, active low |
| code_o | output | 12 | DAC register contents, converter code |
| code_chg_o | output | 1 | One-cycle pulse when code_o changes |

## Verification
Low-byte-only and high-nibble-only writes, each followed by a separate load, show that each select reaches only its own field. A nibble bus value with its upper bits set shows that bits 7:4 are dropped. Holding load low while the bus moves under an open write separates transparent following from edge capture. A combined nibble-write-and-load, sampled one edge early and then on time, pins down both the same-cycle pass-through and the synchronizer latency. Clear alone, clear with load, and a reload of an unchanged value tell apart clearing the DAC register from clearing the input register, and true code changes from rewrites.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

   // Synchronized control bundle, all active low.
   typedef struct packed {
      logic lo_n;
      logic hi_n;
      logic wr_n;
      logic ld_n;
      logic clr_n;
   } dbl_ctrl_t;

   localparam int unsigned CTRL_W = $bits(dbl_ctrl_t);

   // Idle value of the control bundle: every strobe inactive.
   localparam dbl_ctrl_t CTRL_IDLE = '{lo_n: 1'b1, hi_n: 1'b1, wr_n: 1'b1,
                                       ld_n: 1'b1, clr_n: 1'b1};

endpackage

// File: rtl/dbl_sync.sv
module dbl_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("dbl_sync: STAGES must be at least 1");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dbl_input_reg.sv
module dbl_input_reg
   import dbl_pkg::*;
#(
   parameter int unsigned BUS_W = 8,
   parameter int unsigned HI_W  = 4,
   localparam int unsigned CODE_W = BUS_W + HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dbl_ctrl_t         ctl,
   input  logic [BUS_W-1:0]  data,
   output logic [CODE_W-1:0] word_q,
   output logic [CODE_W-1:0] word_nxt
);

   logic             lo_open;
   logic             hi_open;
   logic [BUS_W-1:0] lo_q, lo_nxt;
   logic [HI_W-1:0]  hi_q, hi_nxt;

   assign lo_open = !ctl.lo_n && !ctl.wr_n;
   assign hi_open = !ctl.hi_n && !ctl.wr_n;

   // Transparent-while-open: next value tracks the bus, else holds.
   always_comb begin
      lo_nxt = lo_open ? data : lo_q;
      hi_nxt = hi_open ? data[HI_W-1:0] : hi_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_nxt;
         hi_q <= hi_nxt;
      end
   end

   assign word_q   = {hi_q, lo_q};
   assign word_nxt = {hi_nxt, lo_nxt};

endmodule

// File: rtl/dbl_dac_reg.sv
module dbl_dac_reg
   import dbl_pkg::*;
#(
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dbl_ctrl_t         ctl,
   input  logic [CODE_W-1:0] word_nxt,
   output logic [CODE_W-1:0] code_q,
   output logic              chg_q
);

   logic [CODE_W-1:0] code_nxt;

   // Clear wins over load; load passes the input register through
   // including a value written in this same cycle.
   always_comb begin
      if (!ctl.clr_n)     code_nxt = '0;
      else if (!ctl.ld_n) code_nxt = word_nxt;
      else                code_nxt = code_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         chg_q  <= 1'b0;
      end else begin
         code_q <= code_nxt;
         chg_q  <= (code_nxt != code_q);
      end
   end

endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
   import dbl_pkg::*;
#(
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned HI_W        = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CODE_W     = BUS_W + HI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  bus_i,
   input  logic              lo_sel_n,
   input  logic              hi_sel_n,
   input  logic              wr_n,
   input  logic              ld_n,
   input  logic              clr_n,
   output logic [CODE_W-1:0] code_o,
   output logic              code_chg_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("dac_byte_loader: SYNC_STAGES must be at least 2");
      end
      if (HI_W > BUS_W || HI_W < 1) begin : g_chk_hi
         $error("dac_byte_loader: HI_W must be 1..BUS_W");
      end
   endgenerate

   dbl_ctrl_t         ctl_raw, ctl_s;
   logic [BUS_W-1:0]  bus_s;
   logic [CODE_W-1:0] in_word, in_nxt;

   // Names used by the bound checker.
   logic lo_s, hi_s, ld_s, clr_s;

   assign ctl_raw = '{lo_n: lo_sel_n, hi_n: hi_sel_n, wr_n: wr_n,
                      ld_n: ld_n, clr_n: clr_n};

   dbl_sync #(
      .W       (CTRL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTRL_IDLE)
   ) u_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   // Bus delayed by the same depth so data lines up with its strobes.
   dbl_sync #(
      .W       (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) u_bus_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_i),
      .q     (bus_s)
   );

   dbl_input_reg #(
      .BUS_W (BUS_W),
      .HI_W  (HI_W)
   ) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl_s),
      .data     (bus_s),
      .word_q   (in_word),
      .word_nxt (in_nxt)
   );

   dbl_dac_reg #(
      .CODE_W (CODE_W)
   ) u_dac (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl_s),
      .word_nxt (in_nxt),
      .code_q   (code_o),
      .chg_q    (code_chg_o)
   );

   assign lo_s  = ctl_s.lo_n;
   assign hi_s  = ctl_s.hi_n;
   assign ld_s  = ctl_s.ld_n;
   assign clr_s = ctl_s.clr_n;

endmodule

// File: rtl/dbl_checker.sv
module dbl_checker #(
   parameter int unsigned CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] code_o,
   input logic              code_chg_o,
   input logic [CODE_W-1:0] in_word,
   input logic              lo_s,
   input logic              hi_s,
   input logic              ld_s,
   input logic              clr_s
);

   // R1: reset state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_zero_R1: assert (code_o == '0 && !code_chg_o);
      end
   end

   // R10: pulse marks exactly the cycles with a new code
   assert_chg_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      code_chg_o == (code_o != $past(code_o)));

   // R8 / R7: clear forces zero regardless of load
   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> (code_o == '0));

   // R4: load inactive and no clear, DAC register holds
   assert_dac_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && ld_s) |=> $stable(code_o));

   // R6: both selects idle, input register holds
   assert_input_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_s && hi_s) |=> $stable(in_word));

endmodule

bind dac_byte_loader dbl_checker #(.CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .code_o     (code_o),
   .code_chg_o (code_chg_o),
   .in_word    (in_word),
   .lo_s       (lo_s),
   .hi_s       (hi_s),
   .ld_s       (ld_s),
   .clr_s      (clr_s)
);

// File: tb/dac_byte_loader_test.sv
module dac_byte_loader_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_i = 8'h00;
   logic        lo_sel_n = 1'b1, hi_sel_n = 1'b1, wr_n = 1'b1;
   logic        ld_n = 1'b1, clr_n = 1'b1;
   logic [11:0] code_o;
   logic        code_chg_o;

   int n_vec = 0;
   int n_bad = 0;
   int chg_cnt;
   logic done = 1'b0;

   always #5 clk = ~clk;

   dac_byte_loader uut (
      .clk(clk), .rst_n(rst_n), .bus_i(bus_i),
      .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n), .wr_n(wr_n),
      .ld_n(ld_n), .clr_n(clr_n),
      .code_o(code_o), .code_chg_o(code_chg_o)
   );

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Advance n edges, landing on a falling edge; count change pulses seen.
   task automatic step(input int n);
      chg_cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (code_chg_o) chg_cnt++;
      end
   endtask

   task automatic load_pulse();
      ld_n = 1'b0; step(4);
      ld_n = 1'b1; step(4);
   endtask

   task automatic t_reset();
      check("R1 code after reset", code_o, 12'h000);
      check("R1 pulse after reset", {11'd0, code_chg_o}, 12'h000);
   endtask

   task automatic t_low_byte();
      bus_i = 8'hA5; lo_sel_n = 1'b0; wr_n = 1'b0; step(4);
      wr_n = 1'b1; lo_sel_n = 1'b1; step(1);
      bus_i = 8'hFF; step(4);
      check("R4 hold while load high", code_o, 12'h000);
      load_pulse();
      check("R2 low byte captured and held", code_o, 12'h0A5);
      // transparent follow with load open
      ld_n = 1'b0; lo_sel_n = 1'b0; wr_n = 1'b0; bus_i = 8'h3C; step(4);
      check("R4 follow 3C", code_o, 12'h03C);
      bus_i = 8'h77; step(4);
      check("R2 follow 77", code_o, 12'h077);
      wr_n = 1'b1; lo_sel_n = 1'b1; ld_n = 1'b1; step(4);
   endtask

   task automatic t_high_nibble();
      bus_i = 8'hF6; hi_sel_n = 1'b0; wr_n = 1'b0; step(4);
      wr_n = 1'b1; hi_sel_n = 1'b1; bus_i = 8'h09; step(4);
      check("R3 no change before load", code_o, 12'h077);
      load_pulse();
      check("R3 nibble from bus 3:0 only", code_o, 12'h677);
   endtask

   task automatic t_combined();
      bus_i = 8'h12; lo_sel_n = 1'b0; wr_n = 1'b0; step(4);
      lo_sel_n = 1'b1; wr_n = 1'b1; step(4);
      check("R4 low byte not yet loaded", code_o, 12'h677);
      bus_i = 8'h03; hi_sel_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0;
      step(2);
      check("R9 unchanged at second edge", code_o, 12'h677);
      step(1);
      check("R5 nibble passes through same cycle", code_o, 12'h312);
      check("R10 pulse with new code", {11'd0, code_chg_o}, 12'h001);
      step(1);
      check("R10 pulse one cycle only", {11'd0, code_chg_o}, 12'h000);
      hi_sel_n = 1'b1; wr_n = 1'b1; ld_n = 1'b1; step(4);
   endtask

   task automatic t_ignore();
      bus_i = 8'hEE;
      for (int k = 0; k < 6; k++) begin
         wr_n = ~wr_n; bus_i = bus_i + 8'h11; step(2);
      end
      wr_n = 1'b1; step(4);
      check("R6 output untouched by stray writes", code_o, 12'h312);
      load_pulse();
      check("R6 input register untouched", code_o, 12'h312);
      check("R10 no pulse on same-value reload", chg_cnt[11:0], 12'h000);
   endtask

   task automatic t_clear();
      clr_n = 1'b0; step(4);
      check("R7 clear zeroes code", code_o, 12'h000);
      clr_n = 1'b1; step(4);
      check("R7 stays zero after clear", code_o, 12'h000);
      load_pulse();
      check("R7 input register kept", code_o, 12'h312);
   endtask

   task automatic t_clear_prio();
      clr_n = 1'b0; ld_n = 1'b0; step(6);
      check("R8 clear beats load", code_o, 12'h000);
      clr_n = 1'b1; step(4);
      check("R8 load resumes after clear", code_o, 12'h312);
      check("R10 single pulse on restore", chg_cnt[11:0], 12'h001);
      ld_n = 1'b1; step(4);
   endtask

   initial begin
      step(3);
      t_reset();
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_low_byte();
      t_high_nibble();
      t_combined();
      t_ignore();
      t_clear();
      t_clear_prio();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule